// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block carries a processor core from the moment it accepts an interrupt up to the point where the exception frame is on the supervisor stack. When `start` is seen while idle, it takes a copy of the incoming status register, program counter and supervisor stack pointer. It then publishes a new status word with supervisor mode forced on, both trace bits cleared and the priority mask raised to the accepted level.

Next it runs one interrupt-acknowledge transaction. The request carries a fixed address-space code and the level being acknowledged. The responder ends the transaction in one of three ways, and the ending selects the exception vector. The sequencer then writes a four-word frame, one word per cycle, at descending addresses below the old stack pointer. It then presents the lowered stack pointer and pulses `done`.

The core uses `srOut`, `sspOut` and `vecOut` after the `done` pulse to dispatch the handler.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `ackReq`, `wrEn` and `done` are low, `srOut` is 16'h2700, and `sspOut` and `vecOut` are zero.
- R2: The values of `srIn`, `pcIn`, `sspIn` and `level` on the cycle `start` is accepted are the ones used for the whole sequence. The frame stores the unmodified `srIn` and the given `pcIn`.
- R3: From the cycle after acceptance, `srOut` equals `srIn` with bit 13 (supervisor) set, bits 15 and 14 (trace) cleared, and bits 10:8 (mask) replaced by `level`. All other bits pass through.
- R4: `ackReq` rises the cycle after acceptance. It stays high until a clock edge at which `ackDataRdy`, `ackAuto` or `ackBusErr` is high. While it is high, `ackSpace` is 4'hF and `ackLevel` is the accepted level.
- R5: A transaction ended by `ackDataRdy` yields `vecOut` equal to `ackVector`.
- R6: A transaction ended by `ackAuto` yields `vecOut` equal to 24 plus the accepted level.
- R7: A transaction ended by `ackBusErr` yields `vecOut` equal to 24. If several terminations arrive together, bus error wins over autovector, and autovector wins over data-ready.
- R8: Starting the cycle after termination, `wrEn` is high for exactly four consecutive cycles. The four writes go to SSP-2, SSP-4, SSP-6 and SSP-8, in that order. Their data is `vecOut`×4 (upper six bits zero), PC[15:0], PC[31:16] and the saved SR.
- R9: The cycle after the last write, `done` is high for exactly one cycle and `sspOut` equals SSP-8.
- R10: `start` is ignored from acceptance until `done` has dropped. Changes to `srIn`, `pcIn`, `sspIn` and `level` in that time do not alter the acknowledge, `srOut` or the frame.
- R11: A reset in the middle of a sequence returns the block to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Interrupt accepted, sampled while idle |
| level | input | 3 | Accepted interrupt level |
| srIn | input | 16 | Current status register |
| pcIn | input | 32 | Address of the next instruction |
| sspIn | input | 32 | Current supervisor stack pointer |
| ackReq | output | 1 | Interrupt-acknowledge request |
| ackSpace | output | 4 | Address-space code of the acknowledge (always F) |
| ackLevel | output | 3 | Level driven on the acknowledge address |
| ackDataRdy | input | 1 | Acknowledge ended, device supplies the vector |
| ackVector | input | 8 | Device-supplied vector number |
| ackAuto | input | 1 | Acknowledge ended, autovector requested |
| ackBusErr | input | 1 | Acknowledge ended with bus error |
| wrEn | output | 1 | Stack word write strobe |
| wrAddr | output | 32 | Stack word address |
| wrData | output | 16 | Stack word data |
| srOut | output | 16 | Updated status register |
| sspOut | output | 32 | Updated supervisor stack pointer |
| vecOut | output | 8 | Resolved vector number |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench scrambles the status, PC, stack and level inputs right after acceptance and keeps `start` high. A design that sampled its inputs late would then stack a wrong SR or PC, or restart mid-frame. A design that stacked the modified status word instead of the snapshot would show supervisor set and trace clear in the SR word.

It holds the acknowledge open for several cycles, and it applies all three terminations at once to expose a wrong priority. It also runs autovectors at the extreme levels, where an off-by-one base gives 24 or 32. A stack pointer of 8 drives the frame down to address zero, which catches a wrong step or an early stack-pointer update.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int SR_W     = 16;
  localparam int SR_T1    = 15;
  localparam int SR_T0    = 14;
  localparam int SR_SUP   = 13;
  localparam int MASK_LO  = 8;
  localparam int LVL_W    = 3;
  localparam int FRAME_WORDS = 4;

  typedef enum logic [1:0] {
    VSEL_DEV  = 2'd0,
    VSEL_AUTO = 2'd1,
    VSEL_SPUR = 2'd2
  } vecSel_e;

  typedef struct packed {
    logic    capture;
    logic    latchVec;
    vecSel_e vecSel;
    logic    wrEn;
    logic [1:0] wrIdx;
    logic    commitSsp;
  } ctrlStrb_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      ackDataRdy,
  input  logic      ackAuto,
  input  logic      ackBusErr,
  output logic      ackReq,
  output logic      done,
  output ctrlStrb_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_PUSH, ST_DONE} state_e;

  localparam logic [1:0] LAST_IDX = 2'(FRAME_WORDS - 1);

  state_e     state, nextState;
  logic [1:0] idx;
  logic       anyTerm;

  assign anyTerm = ackDataRdy | ackAuto | ackBusErr;

  always_comb begin
    strb      = '0;
    nextState = state;
    ackReq    = (state == ST_ACK);
    done      = (state == ST_DONE);
    unique case (state)
      ST_IDLE: begin
        strb.capture = start;
        if (start) nextState = ST_ACK;
      end
      ST_ACK: begin
        if (anyTerm) begin
          strb.latchVec = 1'b1;
          nextState     = ST_PUSH;
          if (ackBusErr)   strb.vecSel = VSEL_SPUR;
          else if (ackAuto) strb.vecSel = VSEL_AUTO;
          else             strb.vecSel = VSEL_DEV;
        end
      end
      ST_PUSH: begin
        strb.wrEn      = 1'b1;
        strb.wrIdx     = idx;
        strb.commitSsp = (idx == LAST_IDX);
        if (idx == LAST_IDX) nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= nextState;
      if (state == ST_PUSH) idx <= idx + 2'd1;
      else                  idx <= '0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ackReq && !anyTerm |=> ackReq); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !ackReq && !strb.wrEn); // R9
  AST_PUSH_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.wrEn) |-> done); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq || strb.wrEn) |-> !strb.capture); // R10
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int SPUR_VEC  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [LVL_W-1:0]  level,
  input  logic [SR_W-1:0]   srIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] sspIn,
  input  logic [VEC_W-1:0]  ackVector,
  output logic [LVL_W-1:0]  lvlHeld,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [SR_W-1:0]   wrData,
  output logic [SR_W-1:0]   srOut,
  output logic [ADDR_W-1:0] sspOut,
  output logic [VEC_W-1:0]  vecOut
);
  localparam int WORD_BYTES = SR_W / 8;
  localparam int PAD_W      = SR_W - VEC_W - 2;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;
  localparam logic [SR_W-1:0] CLR_MASK =
    SR_W'((1 << SR_T1) | (1 << SR_T0) | (((1 << LVL_W) - 1) << MASK_LO));

  logic [SR_W-1:0]   srSave;
  logic [ADDR_W-1:0] pcSave, sspBase;
  logic [VEC_W-1:0]  vecNext;
  logic [SR_W-1:0]   srForced;

  always_comb begin
    srForced = (srIn & ~CLR_MASK) | SR_W'(1 << SR_SUP);
    srForced[MASK_LO +: LVL_W] = level;
  end

  always_comb begin
    unique case (strb.vecSel)
      VSEL_AUTO: vecNext = VEC_W'(SPUR_VEC) + VEC_W'(lvlHeld);
      VSEL_SPUR: vecNext = VEC_W'(SPUR_VEC);
      default:   vecNext = ackVector;
    endcase
  end

  assign wrAddr = sspBase - ADDR_W'((32'(strb.wrIdx) + 1) * WORD_BYTES);

  always_comb begin
    unique case (strb.wrIdx)
      2'd0:    wrData = {{PAD_W{1'b0}}, vecOut, 2'b00};
      2'd1:    wrData = pcSave[SR_W-1:0];
      2'd2:    wrData = pcSave[2*SR_W-1:SR_W];
      default: wrData = srSave;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srSave  <= '0;
      pcSave  <= '0;
      sspBase <= '0;
      lvlHeld <= '0;
      srOut   <= SR_RESET;
      sspOut  <= '0;
      vecOut  <= '0;
    end else begin
      if (strb.capture) begin
        srSave  <= srIn;
        pcSave  <= pcIn;
        sspBase <= sspIn;
        lvlHeld <= level;
        srOut   <= srForced;
      end
      if (strb.latchVec)  vecOut <= vecNext;
      if (strb.commitSsp) sspOut <= wrAddr;
    end
  end

  AST_SR_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> srOut[SR_SUP] && !srOut[SR_T1] && !srOut[SR_T0]
                     && srOut[MASK_LO +: LVL_W] == $past(level)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && $past(strb.wrEn) |-> wrAddr == $past(wrAddr) - ADDR_W'(WORD_BYTES)); // R8
  AST_SSP_FINAL: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitSsp |=> sspOut == $past(wrAddr)); // R9
  AST_SPUR_VEC: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchVec && strb.vecSel == VSEL_SPUR |=> vecOut == VEC_W'(SPUR_VEC)); // R7
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int SPUR_VEC  = 24,
  parameter logic [3:0] ACK_SPACE = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        level,
  input  logic [15:0]       srIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] sspIn,
  output logic              ackReq,
  output logic [3:0]        ackSpace,
  output logic [2:0]        ackLevel,
  input  logic              ackDataRdy,
  input  logic [VEC_W-1:0]  ackVector,
  input  logic              ackAuto,
  input  logic              ackBusErr,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [15:0]       wrData,
  output logic [15:0]       srOut,
  output logic [ADDR_W-1:0] sspOut,
  output logic [VEC_W-1:0]  vecOut,
  output logic              done
);
  ctrlStrb_t strb;

  irq_entry_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .ackDataRdy (ackDataRdy),
    .ackAuto    (ackAuto),
    .ackBusErr  (ackBusErr),
    .ackReq     (ackReq),
    .done       (done),
    .strb       (strb)
  );

  irq_entry_dp #(
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .SPUR_VEC (SPUR_VEC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .level     (level),
    .srIn      (srIn),
    .pcIn      (pcIn),
    .sspIn     (sspIn),
    .ackVector (ackVector),
    .lvlHeld   (ackLevel),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .srOut     (srOut),
    .sspOut    (sspOut),
    .vecOut    (vecOut)
  );

  assign wrEn     = strb.wrEn;
  assign ackSpace = ackReq ? ACK_SPACE : 4'h0;

  AST_ACK_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> ackSpace == ACK_SPACE && !wrEn); // R4
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  level = '0;
  logic [15:0] srIn = '0;
  logic [31:0] pcIn = '0, sspIn = '0;
  logic        ackReq, ackDataRdy = 1'b0, ackAuto = 1'b0, ackBusErr = 1'b0;
  logic [3:0]  ackSpace;
  logic [2:0]  ackLevel;
  logic [7:0]  ackVector = '0;
  logic        wrEn, done;
  logic [31:0] wrAddr, sspOut;
  logic [15:0] wrData, srOut;
  logic [7:0]  vecOut;

  int nCmp = 0, nBad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .level(level), .srIn(srIn),
    .pcIn(pcIn), .sspIn(sspIn), .ackReq(ackReq), .ackSpace(ackSpace),
    .ackLevel(ackLevel), .ackDataRdy(ackDataRdy), .ackVector(ackVector),
    .ackAuto(ackAuto), .ackBusErr(ackBusErr), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .srOut(srOut), .sspOut(sspOut), .vecOut(vecOut),
    .done(done)
  );

  typedef struct packed {
    logic [2:0]  lvl;
    logic [15:0] sr;
    logic [31:0] pc;
    logic [31:0] ssp;
    logic [2:0]  term;   // bit0 data, bit1 auto, bit2 bus error
    logic [7:0]  dev;
    logic [3:0]  hold;
    logic [7:0]  expVec;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 16'h0000, 32'h0000_1234, 32'h0000_8000, 3'b001, 8'h40, 4'd0, 8'h40}, // R5
    '{3'd5, 16'hC31F, 32'hDEAD_BEEE, 32'h0001_0000, 3'b010, 8'h77, 4'd2, 8'd29}, // R6
    '{3'd7, 16'h2700, 32'h0000_0100, 32'h0000_0400, 3'b100, 8'h55, 4'd1, 8'd24}, // R7
    '{3'd3, 16'h8015, 32'h00FF_FFFE, 32'h0000_0008, 3'b010, 8'h00, 4'd0, 8'd27}, // R6 edge to 0
    '{3'd2, 16'h4000, 32'h1234_5678, 32'h0000_2000, 3'b001, 8'h0F, 4'd3, 8'h0F}, // R5
    '{3'd7, 16'hFFFF, 32'hCAFE_F00C, 32'hFFFF_FFF0, 3'b010, 8'h00, 4'd0, 8'd31}, // R6 top
    '{3'd4, 16'h0A0A, 32'h0000_0010, 32'h0000_0100, 3'b111, 8'h99, 4'd1, 8'd24}  // R7 priority
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runSeq(input vec_t v);
    logic [15:0] expSr;
    logic [15:0] expData [4];
    expSr = (v.sr & ~16'hC700) | 16'h2000 | (16'(v.lvl) << 8);
    expData[0] = {6'b0, v.expVec, 2'b00};
    expData[1] = v.pc[15:0];
    expData[2] = v.pc[31:16];
    expData[3] = v.sr;
    @(negedge clk);
    level = v.lvl; srIn = v.sr; pcIn = v.pc; sspIn = v.ssp; start = 1'b1;
    @(negedge clk);
    // scramble inputs and keep start high: must be ignored (R10, R2)
    level = ~v.lvl; srIn = ~v.sr; pcIn = ~v.pc; sspIn = ~v.ssp;
    chk("R4 ackReq rise", 32'(ackReq), 32'd1);
    chk("R4 ackSpace", 32'(ackSpace), 32'hF);
    chk("R4 ackLevel", 32'(ackLevel), 32'(v.lvl));
    chk("R3 srOut", 32'(srOut), 32'(expSr));
    for (int i = 0; i < int'(v.hold); i++) begin
      @(negedge clk);
      chk("R4 ackReq held", 32'(ackReq), 32'd1);
      chk("R10 no write while waiting", 32'(wrEn), 32'd0);
    end
    ackDataRdy = v.term[0]; ackAuto = v.term[1]; ackBusErr = v.term[2];
    ackVector = v.dev;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ackDataRdy = 1'b0; ackAuto = 1'b0; ackBusErr = 1'b0;
      if (i == 0) begin
        chk("R5/R6/R7 vecOut", 32'(vecOut), 32'(v.expVec));
        chk("R4 ackReq dropped", 32'(ackReq), 32'd0);
      end
      chk("R8 wrEn", 32'(wrEn), 32'd1);
      chk("R8 wrAddr", wrAddr, v.ssp - 32'(2 * (i + 1)));
      chk("R8 R2 wrData", 32'(wrData), 32'(expData[i]));
      chk("R9 no early done", 32'(done), 32'd0);
    end
    @(negedge clk);
    chk("R9 done", 32'(done), 32'd1);
    chk("R8 four writes only", 32'(wrEn), 32'd0);
    chk("R9 sspOut", sspOut, v.ssp - 32'd8);
    chk("R10 srOut stable", 32'(srOut), 32'(expSr));
    start = 1'b0;
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R10 no restart", 32'(ackReq), 32'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ackReq", 32'(ackReq), 32'd0);
    chk("R1 wrEn", 32'(wrEn), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 srOut", 32'(srOut), 32'h2700);
    chk("R1 sspOut", sspOut, 32'd0);
    chk("R1 vecOut", 32'(vecOut), 32'd0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) runSeq(TBL[k]);

    // R11: reset while waiting on the acknowledge
    @(negedge clk);
    level = 3'd6; srIn = 16'h1234; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 pre ackReq", 32'(ackReq), 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R11 ackReq", 32'(ackReq), 32'd0);
    chk("R11 srOut", 32'(srOut), 32'h2700);
    chk("R11 vecOut", 32'(vecOut), 32'd0);
    rstN = 1'b1;
    ackAuto = 1'b1;
    @(negedge clk);
    ackAuto = 1'b0;
    chk("R11 idle ignores term", 32'(wrEn), 32'd0);

    // R10: start after full recovery is accepted again
    runSeq(TBL[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule